// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block looks at the first six bytes of an incoming frame, which hold the destination address. From those bytes and a few mode inputs it decides whether the frame is kept or dropped. Bytes arrive one per cycle on a qualified byte stream. A start marker flags the first byte of a frame and an end marker flags the last byte. The station address, a 64-entry multicast hash table and the mode bits are plain inputs driven from configuration registers elsewhere.

The address is classified in a fixed order. An all-ones address is broadcast. Otherwise, a group address (or any address when hash-all mode is on) is looked up in the hash table. Otherwise the address is compared exactly with the station address. A miss drops the frame, unless promiscuous mode is on; in that case the frame is kept and its miss flag is raised. The hash index comes from a bytewise CRC-32 engine that runs over the destination bytes as they stream in.

Top module: `rx_dest_filter`

## Requirements
- R1: After reset, `verdict_o`, `accept_o` and `miss_o` are all 0. Bytes that arrive before any start marker produce no verdict.
- R2: A frame whose end marker arrives on byte 1 to 5 gets a verdict in the same clock edge as that byte: `accept_o`=1, `miss_o`=0. No address check is made.
- R3: A destination of six 0xFF bytes is broadcast. It is a miss exactly when `bcast_reject_i`=1. Broadcast takes priority over the group bit, which is set in 0xFF.
- R4: A non-broadcast destination whose first byte has bit 0 set, or any non-broadcast destination while `hash_all_i`=1, is looked up in the hash table. The CRC is reflected CRC-32 with polynomial 0xEDB88320 and initial value 0xFFFFFFFF, fed LSB-first with the six destination bytes and with no final inversion. The index is bits [31:26] of the result. Index bit 5 selects `hash_hi_i` (1) or `hash_lo_i` (0), and index bits [4:0] select the bit in that word. A clear bit is a miss.
- R5: Any other destination is compared exactly with the station address. Byte 0 compares with `sta_hi_i[15:8]`, byte 1 with `sta_hi_i[7:0]`, and bytes 2 to 5 with `sta_lo_i[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Any difference is a miss.
- R6: A miss with `promisc_i`=0 gives `accept_o`=0, `miss_o`=1.
- R7: A miss with `promisc_i`=1 gives `accept_o`=1, `miss_o`=1. A hit gives `accept_o`=1, `miss_o`=0 whatever `promisc_i` is.
- R8: The verdict is registered on the clock edge that takes the sixth byte. It stays unchanged through later bytes and any mode changes until the next start marker.
- R9: A start marker clears `verdict_o` on the edge that takes the first byte, unless that byte also ends the frame.
- R10: When hash lookup applies, it replaces the exact match. A unicast destination equal to the station address is a miss in hash-all mode if its table bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | Byte qualifier |
| sof_i | input | 1 | First byte of frame (with byte_vld_i) |
| eof_i | input | 1 | Last byte of frame (with byte_vld_i) |
| byte_i | input | 8 | Frame byte |
| sta_hi_i | input | 16 | Station address bytes 0 and 1 |
| sta_lo_i | input | 32 | Station address bytes 2 to 5 |
| hash_hi_i | input | 32 | Hash table entries 32 to 63 |
| hash_lo_i | input | 32 | Hash table entries 0 to 31 |
| bcast_reject_i | input | 1 | Broadcast counts as miss |
| hash_all_i | input | 1 | Hash lookup for all non-broadcast addresses |
| promisc_i | input | 1 | Keep missed frames |
| verdict_o | output | 1 | Verdict valid, held until next start |
| accept_o | output | 1 | Frame kept |
| miss_o | output | 1 | Frame classified as miss |

## Verification
Every verdict appears on the clock edge that takes either the sixth byte or the early end marker. No pipeline stage follows, so the bench drives each byte on a falling edge and reads the outputs on the next falling edge, half a cycle after that edge. It records the verdict flag after every byte of a frame. This lets it confirm that the flag is still low after the fifth byte and high after the sixth. It also confirms that later bytes and mode changes leave the held verdict untouched, and that a new start marker clears it within one edge.

// File: rtl/rx_dest_filter_pkg.sv
package rx_dest_filter_pkg;
   localparam int unsigned CRC_W    = 32;
   localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
   localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;

   typedef enum logic [1:0] {
      CLS_BCAST = 2'd0,
      CLS_HASH  = 2'd1,
      CLS_EXACT = 2'd2
   } addr_class_e;

   function automatic logic [CRC_W-1:0] crc_step_byte(input logic [CRC_W-1:0] cur,
                                                      input logic [7:0] d);
      logic [CRC_W-1:0] c;
      c = cur;
      for (int b = 0; b < 8; b++) begin
         c = (c >> 1) ^ ({CRC_W{c[0] ^ d[b]}} & CRC_POLY);
      end
      return c;
   endfunction
endpackage

// File: rtl/rx_dest_crc.sv
module rx_dest_crc
   import rx_dest_filter_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart_i,
   input  logic             step_i,
   input  logic [7:0]       byte_i,
   output logic [CRC_W-1:0] crc_next_o
);
   logic [CRC_W-1:0] crc_q;

   assign crc_next_o = crc_step_byte(restart_i ? CRC_SEED : crc_q, byte_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      crc_q <= CRC_SEED;
      else if (step_i) crc_q <= crc_next_o;
   end
endmodule

// File: rtl/rx_dest_track.sv
module rx_dest_track #(
   parameter int unsigned N_BYTES = 6,
   localparam int unsigned CW     = $clog2(N_BYTES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 byte_vld_i,
   input  logic                 sof_i,
   input  logic                 eof_i,
   input  logic [7:0]           byte_i,
   input  logic [8*N_BYTES-1:0] station_i,
   output logic                 step_o,
   output logic                 last_o,
   output logic                 short_end_o,
   output logic                 bc_o,
   output logic                 ex_o,
   output logic                 grp_o
);
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] pos;
   logic          bc_q, ex_q, grp_q;
   logic [7:0]    exp_b;

   assign pos    = sof_i ? '0 : cnt_q;
   assign step_o = byte_vld_i && (sof_i || (cnt_q < CW'(N_BYTES)));

   always_comb begin
      exp_b = '0;
      for (int k = 0; k < N_BYTES; k++) begin
         if (pos == CW'(k)) exp_b = station_i[8*(N_BYTES-1-k) +: 8];
      end
   end

   assign bc_o        = (sof_i ? 1'b1 : bc_q) && (byte_i == 8'hFF);
   assign ex_o        = (sof_i ? 1'b1 : ex_q) && (byte_i == exp_b);
   assign grp_o       = sof_i ? byte_i[0] : grp_q;
   assign last_o      = step_o && (pos == CW'(N_BYTES - 1));
   assign short_end_o = step_o && eof_i && (pos < CW'(N_BYTES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CW'(N_BYTES);
         bc_q  <= 1'b0;
         ex_q  <= 1'b0;
         grp_q <= 1'b0;
      end else if (step_o) begin
         cnt_q <= (short_end_o) ? CW'(N_BYTES) : pos + 1'b1;
         bc_q  <= bc_o;
         ex_q  <= ex_o;
         grp_q <= grp_o;
      end
   end
endmodule

// File: rtl/rx_dest_decide.sv
module rx_dest_decide
   import rx_dest_filter_pkg::*;
#(
   parameter int unsigned HASH_IDX_W = 6,
   localparam int unsigned TBL_BITS  = 1 << HASH_IDX_W
) (
   input  logic                 bc_i,
   input  logic                 grp_i,
   input  logic                 ex_i,
   input  logic                 hash_all_i,
   input  logic                 bcast_reject_i,
   input  logic                 promisc_i,
   input  logic [CRC_W-1:0]     crc_i,
   input  logic [TBL_BITS-1:0]  table_i,
   output logic                 accept_o,
   output logic                 miss_o
);
   addr_class_e            cls;
   logic [HASH_IDX_W-1:0]  idx;

   assign idx = crc_i[CRC_W-1 -: HASH_IDX_W];

   always_comb begin
      if (bc_i)                    cls = CLS_BCAST;
      else if (grp_i || hash_all_i) cls = CLS_HASH;
      else                         cls = CLS_EXACT;
      case (cls)
         CLS_BCAST: miss_o = bcast_reject_i;
         CLS_HASH:  miss_o = !table_i[idx];
         default:   miss_o = !ex_i;
      endcase
      accept_o = !miss_o || promisc_i;
   end
endmodule

// File: rtl/rx_dest_filter.sv
module rx_dest_filter
   import rx_dest_filter_pkg::*;
#(
   parameter int unsigned N_BYTES    = 6,
   parameter int unsigned HASH_IDX_W = 6,
   parameter int unsigned HASH_WORD  = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        byte_vld_i,
   input  logic        sof_i,
   input  logic        eof_i,
   input  logic [7:0]  byte_i,
   input  logic [15:0] sta_hi_i,
   input  logic [31:0] sta_lo_i,
   input  logic [31:0] hash_hi_i,
   input  logic [31:0] hash_lo_i,
   input  logic        bcast_reject_i,
   input  logic        hash_all_i,
   input  logic        promisc_i,
   output logic        verdict_o,
   output logic        accept_o,
   output logic        miss_o
);
   localparam int unsigned TBL_BITS = 1 << HASH_IDX_W;

   if (N_BYTES != 6) begin : g_bad_bytes
      $error("rx_dest_filter: station ports hold exactly six bytes");
   end
   if (HASH_WORD != 32 || TBL_BITS != 2 * HASH_WORD) begin : g_bad_hash
      $error("rx_dest_filter: hash table must be two 32-bit words");
   end
   if (HASH_IDX_W > CRC_W) begin : g_bad_idx
      $error("rx_dest_filter: hash index wider than CRC");
   end

   logic             step, last, short_end, bc, ex, grp;
   logic             acc_c, miss_c;
   logic [CRC_W-1:0] crc_next;
   logic             vld_q, acc_q, miss_q;

   rx_dest_crc u_crc (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (sof_i),
      .step_i     (step),
      .byte_i     (byte_i),
      .crc_next_o (crc_next)
   );

   rx_dest_track #(.N_BYTES(N_BYTES)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .byte_vld_i  (byte_vld_i),
      .sof_i       (sof_i),
      .eof_i       (eof_i),
      .byte_i      (byte_i),
      .station_i   ({sta_hi_i, sta_lo_i}),
      .step_o      (step),
      .last_o      (last),
      .short_end_o (short_end),
      .bc_o        (bc),
      .ex_o        (ex),
      .grp_o       (grp)
   );

   rx_dest_decide #(.HASH_IDX_W(HASH_IDX_W)) u_decide (
      .bc_i           (bc),
      .grp_i          (grp),
      .ex_i           (ex),
      .hash_all_i     (hash_all_i),
      .bcast_reject_i (bcast_reject_i),
      .promisc_i      (promisc_i),
      .crc_i          (crc_next),
      .table_i        ({hash_hi_i, hash_lo_i}),
      .accept_o       (acc_c),
      .miss_o         (miss_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         acc_q  <= 1'b0;
         miss_q <= 1'b0;
      end else if (short_end) begin
         vld_q  <= 1'b1;
         acc_q  <= 1'b1;
         miss_q <= 1'b0;
      end else if (last) begin
         vld_q  <= 1'b1;
         acc_q  <= acc_c;
         miss_q <= miss_c;
      end else if (byte_vld_i && sof_i) begin
         vld_q  <= 1'b0;
      end
   end

   assign verdict_o = vld_q;
   assign accept_o  = acc_q;
   assign miss_o    = miss_q;

   AST_HOLD_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_o && !(byte_vld_i && sof_i)) |=> ($stable(accept_o) && $stable(miss_o) && verdict_o)) // R8
      else $error("verdict changed without a new frame");
   AST_DROP_IS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      (verdict_o && !accept_o) |-> miss_o) // R6
      else $error("dropped frame without miss");
   AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(verdict_o) && $past(promisc_i)) |-> accept_o) // R7
      else $error("promiscuous frame dropped");
   AST_SOF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && sof_i && !eof_i) |=> !verdict_o) // R9
      else $error("start marker did not clear verdict");
   AST_VERDICT_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(verdict_o) |-> $past(byte_vld_i)) // R1
      else $error("verdict without a byte");
endmodule

// File: tb/tb_rx_dest_filter.sv
module tb_rx_dest_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_vld_i = 1'b0, sof_i = 1'b0, eof_i = 1'b0;
   logic [7:0]  byte_i = '0;
   logic [15:0] sta_hi_i = 16'h0211;
   logic [31:0] sta_lo_i = 32'h2233_4455;
   logic [31:0] hash_hi_i = '0, hash_lo_i = '0;
   logic        bcast_reject_i = 1'b0, hash_all_i = 1'b0, promisc_i = 1'b0;
   logic        verdict_o, accept_o, miss_o;

   int checks = 0;
   int failures = 0;
   logic seen [0:15];

   always #10 clk = ~clk;

   rx_dest_filter dut (.*);

   function automatic logic [5:0] hash_idx(input logic [47:0] d);
      logic [31:0] c;
      c = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
         logic [7:0] b;
         b = d[47-8*i -: 8];
         for (int j = 0; j < 8; j++) begin
            if (c[0] ^ b[j]) c = (c >> 1) ^ 32'hEDB8_8320;
            else             c = c >> 1;
         end
      end
      return c[31:26];
   endfunction

   task automatic chk(input logic [1:0] act, input logic [1:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: actual=%b expected=%b", what, act, exp);
      end
   endtask

   task automatic send(input logic [47:0] d, input int n);
      for (int i = 0; i < n; i++) begin
         byte_vld_i = 1'b1;
         sof_i      = (i == 0);
         eof_i      = (i == n - 1);
         byte_i     = (i < 6) ? d[47-8*i -: 8] : 8'(i);
         @(negedge clk);
         if (i < 16) seen[i] = verdict_o;
      end
      byte_vld_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk({verdict_o, accept_o}, 2'b00, "R1 reset verdict/accept");
      chk({1'b0, miss_o}, 2'b00, "R1 reset miss");
      byte_vld_i = 1'b1; byte_i = 8'hFF;
      repeat (8) @(negedge clk);
      byte_vld_i = 1'b0;
      @(negedge clk);
      chk({1'b0, verdict_o}, 2'b00, "R1 stray bytes no verdict");
   endtask

   task automatic t_exact();
      send(48'h0211_2233_4455, 8);
      chk({accept_o, miss_o}, 2'b10, "R5 exact hit");
      chk({seen[4], seen[5]}, 2'b01, "R8 verdict after sixth byte");
      send(48'h0211_2233_4454, 6);
      chk({accept_o, miss_o}, 2'b01, "R5 R6 byte5 differs dropped");
      send(48'h0311_2233_4455, 6);
      chk({accept_o, miss_o}, 2'b01, "R4 group bit uses empty hash");
      send(48'h0210_2233_4455, 6);
      chk({accept_o, miss_o}, 2'b01, "R5 byte1 differs");
      promisc_i = 1'b1;
      send(48'h0211_2233_5455, 6);
      chk({accept_o, miss_o}, 2'b11, "R7 promisc keeps miss");
      send(48'h0211_2233_4455, 6);
      chk({accept_o, miss_o}, 2'b10, "R7 promisc hit no miss");
      promisc_i = 1'b0;
   endtask

   task automatic t_bcast();
      send(48'hFFFF_FFFF_FFFF, 6);
      chk({accept_o, miss_o}, 2'b10, "R3 broadcast allowed");
      bcast_reject_i = 1'b1;
      hash_lo_i = '1; hash_hi_i = '1;
      send(48'hFFFF_FFFF_FFFF, 6);
      chk({accept_o, miss_o}, 2'b01, "R3 broadcast rejected over hash");
      promisc_i = 1'b1;
      send(48'hFFFF_FFFF_FFFF, 6);
      chk({accept_o, miss_o}, 2'b11, "R3 R7 broadcast rejected promisc");
      promisc_i = 1'b0; bcast_reject_i = 1'b0;
      hash_lo_i = '0; hash_hi_i = '0;
   endtask

   task automatic t_hash(input logic [47:0] d);
      logic [5:0] ix;
      logic [63:0] tbl;
      ix  = hash_idx(d);
      tbl = 64'd1 << ix;
      {hash_hi_i, hash_lo_i} = tbl;
      send(d, 6);
      chk({accept_o, miss_o}, 2'b10, $sformatf("R4 hash hit idx=%0d", ix));
      {hash_hi_i, hash_lo_i} = ~tbl;
      send(d, 6);
      chk({accept_o, miss_o}, 2'b01, $sformatf("R4 hash miss idx=%0d", ix));
      hash_hi_i = '0; hash_lo_i = '0;
   endtask

   task automatic t_hash_all();
      logic [5:0] ix;
      hash_all_i = 1'b1;
      send(48'h0211_2233_4455, 6);
      chk({accept_o, miss_o}, 2'b01, "R10 hash-all overrides exact match");
      ix = hash_idx(48'h0211_2233_4455);
      {hash_hi_i, hash_lo_i} = 64'd1 << ix;
      send(48'h0211_2233_4455, 6);
      chk({accept_o, miss_o}, 2'b10, "R10 hash-all table hit");
      hash_all_i = 1'b0; hash_hi_i = '0; hash_lo_i = '0;
   endtask

   task automatic t_short();
      send(48'h9999_9999_0000, 4);
      chk({seen[3], accept_o}, 2'b11, "R2 four-byte frame accepted at last byte");
      chk({1'b0, miss_o}, 2'b00, "R2 short frame no miss");
      send(48'h9900_0000_0000, 1);
      chk({seen[0], accept_o}, 2'b11, "R2 one-byte frame");
   endtask

   task automatic t_hold();
      send(48'h0211_2233_4400, 12);
      chk({accept_o, miss_o}, 2'b01, "R8 miss held through trailing bytes");
      promisc_i = 1'b1;
      repeat (2) @(negedge clk);
      chk({verdict_o, accept_o}, 2'b10, "R8 mode change ignored after verdict");
      promisc_i = 1'b0;
      byte_vld_i = 1'b1; sof_i = 1'b1; byte_i = 8'h02;
      @(negedge clk);
      chk({1'b0, verdict_o}, 2'b00, "R9 start clears verdict");
      sof_i = 1'b0;
      for (int i = 1; i < 6; i++) begin
         byte_i = sta_hi_i[7:0];
         if (i >= 2) byte_i = sta_lo_i[8*(5-i) +: 8];
         @(negedge clk);
      end
      byte_vld_i = 1'b0;
      chk({verdict_o, accept_o}, 2'b11, "R9 R5 new frame verdict");
   endtask

   initial begin
      #4_000_000;
      failures++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_exact();
      t_bcast();
      t_hash(48'h0100_5E00_0001);
      t_hash(48'h3333_0000_00FB);
      t_hash(48'hAB12_3456_789A);
      t_hash_all();
      t_short();
      t_hold();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule